// File: doc/BRIEF.md
# Dual Timing-Mode FIFO Controller

This block is the storage and control core of a single-clock FIFO. It holds a parameterised memory array, the write and read pointers, an output register and five active-level status outputs. Two choices are latched while master reset is held low. The first is the timing mode. In standard mode every word, the first one included, is moved to the output register by a read request. In fall-through mode the head word is moved to the output register without any request, and the output register counts as one more storage slot. The second choice is the retransmit latency, either zero-cycle or one-cycle.

The meaning of two of the status pins depends on the timing mode. `ef_or` is an empty flag in standard mode and an output-ready flag in fall-through mode. `ff_ir` is a full flag in standard mode and an input-ready-blocked flag in fall-through mode. The half-full, almost-empty and almost-full outputs use thresholds that shift by one word in fall-through mode. The almost-empty and almost-full offsets come in as plain inputs.

A partial reset empties the FIFO and keeps the latched modes. A retransmit request rewinds reading to the first memory location so that data can be read a second time.

Top module: `dualmode_fifo`

## Requirements
- R1: While `mrst_n` is low, `ft_sel` is latched: 0 selects standard mode and 1 selects fall-through mode. `rt0_sel` is latched at the same time: 1 selects zero-latency retransmit and 0 selects one-cycle retransmit. A partial reset (`prst_n` low at a clock edge) leaves both settings unchanged.
- R2: In standard mode, a read (`rd_en` high at an edge while a readable word exists) loads the oldest unread word into `rd_data` at that edge. Words come out in write order.
- R3: A written word becomes readable one edge after the edge that wrote it. In standard mode `ef_or` is 0 while no readable word exists and 1 otherwise.
- R4: A write (`wr_en` high) is accepted unless the memory holds D words, and a blocked write changes nothing. In standard mode `ff_ir` is 0 exactly while the memory holds D words, so one read releases it.
- R5: In fall-through mode, the first word written into an empty FIFO appears on `rd_data` with no read request, and `ef_or` drops to 0 after the third rising edge counting the write edge. Each later word needs `rd_en` high while the output register is valid. `ef_or` is 0 exactly while the output register holds a valid word.
- R6: In fall-through mode `ff_ir` is 1 exactly while the memory holds D words. Together with the output register, the FIFO holds D+1 words.
- R7: The stored count is the write pointer minus the read pointer, plus one in fall-through mode when the output register is valid. `hf_n` is 0 when this count is at least D/2+1 in standard mode, or at least D/2+2 in fall-through mode.
- R8: `pae_n` is 0 when the stored count is at most `ae_off` in standard mode, or at most `ae_off`+1 in fall-through mode.
- R9: `paf_n` is 0 when the stored count is at least D−`af_off` in standard mode, or at least D+1−`af_off` in fall-through mode.
- R10: A read request while no readable word exists is ignored: `rd_data` keeps its value and no word is skipped.
- R11: Master reset (asynchronous) and partial reset (synchronous) both return the pointers to the first location and clear `rd_data` to zero. After either reset the FIFO reports empty.
- R12: With zero-latency retransmit selected, `rt_req` high at an edge puts the word at memory location 0 on `rd_data` at that same edge, and the next read returns location 1. The write pointer is not moved.
- R13: With one-cycle retransmit selected, `rt_req` rewinds the read pointer. For the following cycle, `ef_or` shows empty (standard) or not-ready (fall-through) and read requests are ignored. At the end of that cycle, location 0 is loaded into `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| mrst_n | input | 1 | Master reset, active low, asynchronous; latches the mode inputs |
| prst_n | input | 1 | Partial reset, active low, synchronous |
| ft_sel | input | 1 | Timing mode sampled at master reset (1 = fall-through) |
| rt0_sel | input | 1 | Retransmit latency sampled at master reset (1 = zero latency) |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read request |
| rt_req | input | 1 | Retransmit request |
| ae_off | input | AW | Almost-empty offset |
| af_off | input | AW | Almost-full offset |
| rd_data | output | WIDTH | Output register |
| ef_or | output | 1 | Empty flag (standard) / output-ready, active low (fall-through) |
| ff_ir | output | 1 | Full flag, active low (standard) / input-ready blocked (fall-through) |
| hf_n | output | 1 | Half-full, active low |
| pae_n | output | 1 | Almost-empty, active low |
| paf_n | output | 1 | Almost-full, active low |

## Verification
Single writes followed by isolated reads show the one-edge visibility delay and, in fall-through mode, the three-edge arrival of the first word. A fill to capacity with one write too many separates the D-word capacity of standard mode from the D+1-word capacity of fall-through mode, and shows that the extra write is dropped. A retransmit in each latency, made after a partial read, shows the same-edge reload against the one-cycle blind window. Long runs of random simultaneous reads and writes in both modes test every flag threshold against a behavioural model at each clock.

// File: rtl/dualmode_fifo.sv
module dualmode_fifo #(
  parameter int WIDTH = 8,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic             ft_sel,
  input  logic             rt0_sel,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic             rt_req,
  input  logic [AW-1:0]    ae_off,
  input  logic [AW-1:0]    af_off,
  output logic [WIDTH-1:0] rd_data,
  output logic             ef_or,
  output logic             ff_ir,
  output logic             hf_n,
  output logic             pae_n,
  output logic             paf_n
);
  localparam int D  = 1 << AW;
  localparam int PW = AW + 1;

  logic [WIDTH-1:0] mem [D];
  logic [PW-1:0]    wptr, rptr, wvis;
  logic             ft, rt0, ovld, rt_hold;
  logic [PW-1:0]    wcnt, rcnt;
  logic [PW:0]      cnt;
  logic             full, has_r, wr_ok, take, wvis_nz;
  logic [WIDTH-1:0] head, first;

  assign wcnt    = wptr - rptr;
  assign rcnt    = wvis - rptr;
  assign cnt     = {1'b0, wcnt} + {{PW{1'b0}}, ft & ovld};
  assign full    = (wcnt == PW'(D));
  assign has_r   = (rcnt != '0);
  assign wr_ok   = wr_en & ~full;
  assign wvis_nz = (wvis != '0);
  assign head    = mem[rptr[AW-1:0]];
  assign first   = mem[0];
  assign take    = ~rt_req & ~rt_hold &
                   (ft ? (has_r & (~ovld | rd_en)) : (rd_en & has_r));

  always_ff @(posedge clk)
    if (mrst_n && prst_n && wr_ok) mem[wptr[AW-1:0]] <= wr_data;

  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      ft      <= ft_sel;
      rt0     <= rt0_sel;
      wptr    <= '0;
      rptr    <= '0;
      wvis    <= '0;
      rd_data <= '0;
      ovld    <= 1'b0;
      rt_hold <= 1'b0;
    end else if (!prst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      wvis    <= '0;
      rd_data <= '0;
      ovld    <= 1'b0;
      rt_hold <= 1'b0;
    end else begin
      wvis <= wptr;
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rt_req) begin
        rt_hold <= ~rt0;
        ovld    <= 1'b0;
        rptr    <= '0;
        if (rt0 && wvis_nz) begin
          rd_data <= first;
          rptr    <= PW'(1);
          ovld    <= ft;
        end
      end else if (rt_hold) begin
        rt_hold <= 1'b0;
        if (wvis_nz) begin
          rd_data <= first;
          rptr    <= PW'(1);
          ovld    <= ft;
        end
      end else if (take) begin
        rd_data <= head;
        rptr    <= rptr + 1'b1;
        ovld    <= ft;
      end else if (rd_en) begin
        ovld <= 1'b0;
      end
    end
  end

  assign ef_or = rt_hold ? ft : (ft ? ~ovld : has_r);
  assign ff_ir = ft ? full : ~full;
  assign hf_n  = !(int'(cnt) >= D / 2 + 1 + int'(ft));
  assign pae_n = !(int'(cnt) <= int'(ae_off) + int'(ft));
  assign paf_n = !(int'(cnt) >= D - int'(af_off) + int'(ft));
endmodule

// File: rtl/dualmode_fifo_chk.sv
module dualmode_fifo_chk #(
  parameter int WIDTH = 8,
  parameter int AW    = 4
) (
  input logic             clk,
  input logic             mrst_n,
  input logic             prst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic             rt_req,
  input logic             ft,
  input logic             rt0,
  input logic             rt_hold,
  input logic             ovld,
  input logic [AW:0]      wptr,
  input logic [AW:0]      rptr,
  input logic [AW:0]      wvis,
  input logic [WIDTH-1:0] rd_data
);
  localparam int D = 1 << AW;

  // R4
  full_block_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (prst_n && wr_en && (AW+1)'(wptr - rptr) == (AW+1)'(D)) |=> $stable(wptr));

  // R10
  empty_read_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (prst_n && !ft && rd_en && wvis == rptr && !rt_req && !rt_hold) |=> $stable(rd_data));

  // R11
  prst_clear_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> (rd_data == '0 && wptr == '0 && rptr == '0));

  // R1
  mode_keep_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> ($stable(ft) && $stable(rt0)));

  // R12
  zero_rt_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (prst_n && rt_req && rt0 && wvis != '0) |=> (rptr == (AW+1)'(1) && !rt_hold));

  // R13
  slow_rt_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (prst_n && rt_req && !rt0) |=> (rptr == '0 && rt_hold));

  // R5
  std_no_valid_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    !ft |-> !ovld);
endmodule

bind dualmode_fifo dualmode_fifo_chk #(.WIDTH(WIDTH), .AW(AW)) u_chk (
  .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .wr_en(wr_en), .rd_en(rd_en),
  .rt_req(rt_req), .ft(ft), .rt0(rt0), .rt_hold(rt_hold), .ovld(ovld),
  .wptr(wptr), .rptr(rptr), .wvis(wvis), .rd_data(rd_data));

// File: tb/tb_dualmode_fifo.sv
module tb_dualmode_fifo;
  localparam int W  = 8;
  localparam int AW = 4;
  localparam int D  = 1 << AW;

  logic clk = 1'b0;
  logic mrst_n = 1'b1, prst_n = 1'b1, ft_sel = 1'b0, rt0_sel = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, rt_req = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [AW-1:0] ae_off = 4'd3, af_off = 4'd2;
  logic [W-1:0] rd_data;
  logic ef_or, ff_ir, hf_n, pae_n, paf_n;

  always #4 clk = ~clk;

  dualmode_fifo #(.WIDTH(W), .AW(AW)) dut (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ft_sel(ft_sel), .rt0_sel(rt0_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rt_req(rt_req),
    .ae_off(ae_off), .af_off(af_off), .rd_data(rd_data), .ef_or(ef_or),
    .ff_ir(ff_ir), .hf_n(hf_n), .pae_n(pae_n), .paf_n(paf_n));

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [W-1:0] m_mem [D];
  logic [W-1:0] m_dout;
  int  m_w, m_wv, m_r, t_ow, t_memw, t_memr;
  bit  m_ft, m_rt0, m_ovld, m_hold, m_live = 0;

  task automatic m_clear();
    m_w = 0; m_wv = 0; m_r = 0; m_dout = '0; m_ovld = 0; m_hold = 0;
  endtask

  always @(posedge clk) begin
    if (!mrst_n) begin
      m_ft = ft_sel; m_rt0 = rt0_sel; m_clear(); m_live = 1;
    end else if (!prst_n) begin
      m_clear();
    end else begin
      t_ow = m_w; t_memw = m_w - m_r; t_memr = m_wv - m_r;
      if (rt_req) begin
        m_ovld = 0; m_r = 0; m_hold = !m_rt0;
        if (m_rt0 && m_wv > 0) begin m_dout = m_mem[0]; m_r = 1; m_ovld = m_ft; end
      end else if (m_hold) begin
        m_hold = 0;
        if (m_wv > 0) begin m_dout = m_mem[0]; m_r = 1; m_ovld = m_ft; end
      end else if (m_ft) begin
        if (t_memr > 0 && (!m_ovld || rd_en)) begin
          m_dout = m_mem[m_r % D]; m_r++; m_ovld = 1;
        end else if (rd_en) m_ovld = 0;
      end else if (rd_en && t_memr > 0) begin
        m_dout = m_mem[m_r % D]; m_r++;
      end
      if (wr_en && t_memw < D) begin m_mem[t_ow % D] = wr_data; m_w++; end
      m_wv = t_ow;
    end
  end

  always @(negedge clk) begin
    #3;
    if (mrst_n && m_live) begin
      int cnt;
      cnt = (m_w - m_r) + ((m_ft && m_ovld) ? 1 : 0);
      chk("R2 rd_data", int'(rd_data), int'(m_dout));
      chk("R3 ef_or", int'(ef_or),
          m_hold ? int'(m_ft) : (m_ft ? int'(!m_ovld) : int'((m_wv - m_r) != 0)));
      chk("R4 ff_ir", int'(ff_ir), m_ft ? int'((m_w - m_r) == D) : int'((m_w - m_r) != D));
      chk("R7 hf_n", int'(hf_n), int'(!(cnt >= D / 2 + 1 + int'(m_ft))));
      chk("R8 pae_n", int'(pae_n), int'(!(cnt <= int'(ae_off) + int'(m_ft))));
      chk("R9 paf_n", int'(paf_n), int'(!(cnt >= D - int'(af_off) + int'(m_ft))));
    end
  end

  task automatic step(input logic w, input logic [W-1:0] d, input logic r, input logic t);
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r; rt_req = t;
    #1;
  endtask

  task automatic mreset(input logic ft, input logic rt0);
    @(negedge clk);
    wr_en = 0; rd_en = 0; rt_req = 0; prst_n = 1;
    mrst_n = 0; ft_sel = ft; rt0_sel = rt0;
    repeat (2) @(negedge clk);
    mrst_n = 1;
    #1;
  endtask

  task automatic traffic(input int n);
    for (int i = 0; i < n; i++)
      step(1'($urandom_range(0, 1)), W'($urandom), 1'($urandom_range(0, 2) == 0), 1'b0);
    for (int i = 0; i < n; i++)
      step(1'($urandom_range(0, 3) == 0), W'($urandom), 1'($urandom_range(0, 1)), 1'b0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    // ---------- standard mode, one-cycle retransmit ----------
    mreset(1'b0, 1'b0);
    chk("R11 reset rd_data", int'(rd_data), 0);
    chk("R11 reset ef_or empty", int'(ef_or), 0);
    chk("R1 std ff_ir", int'(ff_ir), 1);
    chk("R8 reset pae_n", int'(pae_n), 0);
    chk("R7 reset hf_n", int'(hf_n), 1);
    step(1, 8'hA1, 0, 0);
    step(0, 0, 0, 0);
    chk("R3 not yet readable", int'(ef_or), 0);
    step(0, 0, 0, 0);
    chk("R3 readable", int'(ef_or), 1);
    chk("R2 no auto load", int'(rd_data), 0);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    chk("R2 read word", int'(rd_data), 8'hA1);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    chk("R10 empty read ignored", int'(rd_data), 8'hA1);
    for (int i = 0; i < D; i++) step(1, W'(8'h10 + i), 0, 0);
    step(1, 8'hEE, 0, 0);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    chk("R4 full flag", int'(ff_ir), 0);
    chk("R7 half full", int'(hf_n), 0);
    chk("R9 almost full", int'(paf_n), 0);
    chk("R8 not almost empty", int'(pae_n), 1);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    chk("R4 read releases full", int'(ff_ir), 1);
    chk("R2 order first", int'(rd_data), 8'h10);
    for (int i = 1; i < D; i++) step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    chk("R4 blocked write lost", int'(rd_data), 8'h1F);
    chk("R10 empty after drain", int'(ef_or), 0);
    // partial reset keeps standard mode
    @(negedge clk); prst_n = 0;
    @(negedge clk); prst_n = 1; #1;
    chk("R11 prst rd_data", int'(rd_data), 0);
    chk("R11 prst empty", int'(ef_or), 0);
    for (int i = 0; i < 4; i++) step(1, W'(8'hB0 + i), 0, 0);
    step(0, 0, 0, 0);
    chk("R1 std kept after prst", int'(rd_data), 0);
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    chk("R2 second word", int'(rd_data), 8'hB1);
    step(0, 0, 0, 1);
    step(0, 0, 1, 0);
    chk("R13 forced empty", int'(ef_or), 0);
    step(0, 0, 0, 0);
    chk("R13 first word reloaded", int'(rd_data), 8'hB0);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    chk("R13 read resumes", int'(rd_data), 8'hB1);
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    chk("R13 write pointer kept", int'(rd_data), 8'hB3);
    traffic(300);

    // ---------- fall-through mode, zero-latency retransmit ----------
    mreset(1'b1, 1'b1);
    chk("R1 ft not ready", int'(ef_or), 1);
    chk("R6 ft input ready", int'(ff_ir), 0);
    step(1, 8'hC0, 0, 0);
    step(0, 0, 0, 0);
    chk("R5 edge one", int'(ef_or), 1);
    step(0, 0, 0, 0);
    chk("R5 edge two", int'(rd_data), 0);
    step(0, 0, 0, 0);
    chk("R5 falls through", int'(rd_data), 8'hC0);
    chk("R5 output ready", int'(ef_or), 0);
    step(1, 8'hC1, 0, 0);
    step(1, 8'hC2, 0, 0);
    repeat (3) step(0, 0, 0, 0);
    chk("R5 later word waits", int'(rd_data), 8'hC0);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    chk("R5 read advances", int'(rd_data), 8'hC1);
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    chk("R12 same-edge reload", int'(rd_data), 8'hC0);
    chk("R12 ready", int'(ef_or), 0);
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    chk("R12 continues", int'(rd_data), 8'hC2);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    chk("R12 write pointer kept", int'(ef_or), 1);
    mreset(1'b1, 1'b1);
    for (int i = 0; i < D + 2; i++) step(1, W'(8'hE0 + i), 0, 0);
    repeat (3) step(0, 0, 0, 0);
    chk("R6 memory full", int'(ff_ir), 1);
    chk("R7 ft half full", int'(hf_n), 0);
    chk("R6 head word", int'(rd_data), 8'hE0);
    for (int i = 0; i < D; i++) step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    chk("R6 D+1 words held", int'(rd_data), 8'hF0);
    chk("R6 still valid", int'(ef_or), 0);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    chk("R5 drained", int'(ef_or), 1);
    traffic(300);

    // ---------- fall-through with one-cycle retransmit ----------
    mreset(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) step(1, W'(8'h70 + i), 0, 0);
    repeat (3) step(0, 0, 0, 0);
    step(0, 0, 1, 0);
    step(0, 0, 0, 1);
    step(0, 0, 1, 0);
    chk("R13 ft not ready", int'(ef_or), 1);
    step(0, 0, 0, 0);
    chk("R13 ft reload", int'(rd_data), 8'h70);
    chk("R13 ft ready", int'(ef_or), 0);
    traffic(200);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule